// File: doc/BRIEF.md
# Floating-Point Normalise, Round and Pack Stage

This block is the final stage of a floating-point datapath. It receives an unpacked result (a sign, a signed unbiased exponent and a 64-bit fraction) and turns it into a packed 64-bit register word. The fraction carries three bits below the 52 stored fraction bits: two guard bits and one sticky bit. Internally the value 1.0 is bit 55 of the fraction.

The stage brings the fraction into the range [1,2) and handles underflow before rounding. Underflow either denormalises the value or, when its trap is enabled, wraps the exponent by a format bias. The stage then rounds to the selected format's step in one of four modes. Overflow either saturates to infinity or to the largest finite value, or, when its trap is enabled, wraps the exponent. Single and double results share the same 64-bit layout: sign in bit 63, exponent field in bits 62:52 (bias 0x3FF) and fraction in bits 51:0.

The datapath is combinational and feeds one output register. Upstream and downstream use a valid/ready handshake, and a result is held until it is taken.

Top module: `fp_round_pack`

## Requirements
- R1: A fraction at or above 2.0 (any of bits 63:56 set) is shifted right until it is below 2.0, and each shift adds one to the exponent. Every bit shifted out is ORed into bit 0.
- R2: A nonzero fraction below 1.0 (bit 55 clear, bits 63:56 clear) is shifted left until bit 55 is set, and each shift subtracts one from the exponent. Bit 0 is copied into each vacated low bit.
- R3: With `dbl_i`=1 the format is double: exponent range -1022..+1023, rounding step 2^3. With `dbl_i`=0 the format is single: exponent range -126..+127, rounding step 2^32, so packed fraction bits 28:0 end up zero after rounding.
- R4: If the normalised exponent is below the minimum and `trap_uf_i`=0, the inexact flag is set. The fraction is shifted right with sticky until the exponent reaches the minimum, and the result is packed with exponent field 0. If rounding then gives a zero fraction, the underflow flag is also set.
- R5: If the normalised exponent is below the minimum and `trap_uf_i`=1, the inexact and underflow flags are set, and 192 (single) or 1536 (double) is added to the exponent. No denormalisation takes place.
- R6: Rounding happens only when bits below the step are nonzero, and it always sets inexact. `rnd_i` encoding: 00 nearest, 01 toward zero (truncate), 10 toward minus infinity (round up in magnitude only when negative), 11 toward plus infinity (round up in magnitude only when positive).
- R7: In nearest mode the closer step wins. An exact half step rounds to the candidate whose step bit is zero.
- R8: If rounding carries the fraction to 2.0, it is halved and one is added to the exponent. If a denormal rounds to exactly 1.0, the result is the smallest normal number (exponent field 1).
- R9: If the exponent exceeds the maximum and `trap_of_i`=1, the overflow and inexact flags are set, and 192 (single) or 1536 (double) is subtracted from the exponent.
- R10: If the exponent exceeds the maximum and `trap_of_i`=0, the overflow and inexact flags are set, and the result saturates. Nearest gives infinity and toward zero gives the largest finite value. Toward minus infinity gives infinity only for negative values, and toward plus infinity only for positive values. Infinity is exponent field 0x7FF with fraction 0.
- R11: The packed result is {sign, exponent field, fraction bits 54:3}. The exponent field is the exponent plus 0x3FF, or 0x7FF above the maximum, or 0 below the minimum.
- R12: A zero input fraction gives a zero result with the input sign and no flags set.
- R13: A result appears one clock after it is accepted (`in_valid_i` and `in_ready_o` both high). The result and flags stay stable while `out_valid_o` is high and `out_ready_i` is low. `in_ready_o` is low in that state, and after reset `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Unpacked operand present |
| in_ready_o | output | 1 | Stage can take an operand |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W | Signed unbiased exponent |
| frac_i | input | 64 | Fraction, 1.0 at bit 55, three bits below the stored LSB |
| dbl_i | input | 1 | 1 = double format, 0 = single format |
| rnd_i | input | 2 | Rounding mode (see R6) |
| trap_uf_i | input | 1 | Underflow trap enable |
| trap_of_i | input | 1 | Overflow trap enable |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 64 | Packed result |
| inexact_o | output | 1 | Inexact flag |
| underflow_o | output | 1 | Underflow flag |
| overflow_o | output | 1 | Overflow flag |

## Verification
The bench aims at the points where a wrong stage fails without any visible alarm:
- Sticky bits are lost in the right shift, so ties are rounded to even when they should round up.
- The left normaliser does not copy bit 0, so flags and results change for tiny inputs.
- Denormals round up to 1.0 but keep exponent field 0.
- Carry-out to 2.0 is left unrenormalised, so the fraction wraps to zero.
- The directed modes are swapped for negative values.
- Overflow saturates to the wrong one of infinity and the largest finite value.

Both trap wraps are checked with exact packed values in each format. Randomised values in both formats, all modes and both trap settings are compared with an independent loop-based model.

// File: rtl/fprp_pkg.sv
package fprp_pkg;
  localparam int FRAC_W   = 64;
  localparam int MANT_W   = 52;
  localparam int GRD_W    = 3;
  localparam int ONE_POS  = MANT_W + GRD_W;     // 55
  localparam int BIAS     = 1023;
  localparam int DBL_MAX  = 1023;
  localparam int DBL_MIN  = -1022;
  localparam int SGL_MAX  = 127;
  localparam int SGL_MIN  = -126;
  localparam int DBL_WRAP = 1536;
  localparam int SGL_WRAP = 192;
  localparam int DBL_STEP = GRD_W;                          // 2^3
  localparam int SGL_STEP = MANT_W - 23 + GRD_W;            // 2^32
  localparam logic [FRAC_W-1:0] ONE_F = FRAC_W'(1) << ONE_POS;
  localparam logic [FRAC_W-1:0] TWO_F = ONE_F << 1;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_DOWN = 2'b10,
    RND_UP   = 2'b11
  } rnd_e;
endpackage

// File: rtl/fprp_norm.sv
module fprp_norm import fprp_pkg::*; #(
  parameter int XW = 17
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [XW-1:0] exp_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [XW-1:0] exp_o
);
  logic [5:0]           msb;
  logic [5:0]           k;
  logic signed [XW-1:0] kx;
  logic [FRAC_W-1:0]    mask;

  always_comb begin
    msb = '0;
    for (int i = 0; i < FRAC_W; i++) if (frac_i[i]) msb = i[5:0];
  end

  always_comb begin
    frac_o = frac_i;
    exp_o  = exp_i;
    k      = '0;
    mask   = '0;
    kx     = '0;
    if (msb > 6'(ONE_POS)) begin
      k      = msb - 6'(ONE_POS);
      mask   = (FRAC_W'(1) << k) - FRAC_W'(1);
      kx     = {{(XW-6){1'b0}}, k};
      frac_o = (frac_i >> k) | {{(FRAC_W-1){1'b0}}, |(frac_i & mask)};
      exp_o  = exp_i + kx;
    end else if (msb < 6'(ONE_POS)) begin
      k      = 6'(ONE_POS) - msb;
      mask   = (FRAC_W'(1) << k) - FRAC_W'(1);
      kx     = {{(XW-6){1'b0}}, k};
      // bit 0 is replicated into the vacated bits to keep stickiness
      frac_o = (frac_i << k) | (frac_i[0] ? mask : '0);
      exp_o  = exp_i - kx;
    end
  end

  always_comb begin
    if (frac_i != '0)
      p_norm_window_r1: assert (frac_o[FRAC_W-1:ONE_POS+1] == '0 && frac_o[ONE_POS]);
  end
endmodule

// File: rtl/fprp_round.sv
module fprp_round import fprp_pkg::*; #(
  parameter int XW = 17
) (
  input  logic                 sign_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 dbl_i,
  input  logic [1:0]           rnd_i,
  input  logic                 trap_uf_i,
  output logic signed [XW-1:0] exp_o,
  output logic [FRAC_W-1:0]    frac_o,
  output logic                 inexact_o,
  output logic                 underflow_o
);
  logic signed [XW-1:0] min_e, wrap, d;
  logic [5:0]           sh;
  logic [FRAC_W-1:0]    eps, lomask, maxf, lo, hi, sub, f;
  logic                 up;

  always_comb begin
    min_e  = dbl_i ? XW'(DBL_MIN) : XW'(SGL_MIN);
    wrap   = dbl_i ? XW'(DBL_WRAP) : XW'(SGL_WRAP);
    eps    = FRAC_W'(1) << (dbl_i ? DBL_STEP : SGL_STEP);
    lomask = eps - FRAC_W'(1);
    maxf   = TWO_F - eps;
    exp_o  = exp_i;
    f      = frac_i;
    inexact_o   = 1'b0;
    underflow_o = 1'b0;
    d  = '0;
    sh = '0;
    lo = '0;
    hi = '0;
    sub = '0;
    up  = 1'b0;
    if (exp_i < min_e) begin
      inexact_o = 1'b1;
      if (trap_uf_i) begin
        underflow_o = 1'b1;
        exp_o       = exp_i + wrap;
      end else begin
        d  = min_e - exp_i;
        sh = (d > XW'(63)) ? 6'd63 : d[5:0];
        f  = (f >> sh) | {{(FRAC_W-1){1'b0}}, |(f & ((FRAC_W'(1) << sh) - FRAC_W'(1)))};
        exp_o = min_e - XW'(1);
      end
    end
    sub = f & lomask;
    if (sub != '0) begin
      lo = f & maxf;
      hi = lo + eps;
      unique case (rnd_e'(rnd_i))
        RND_ZERO: up = 1'b0;
        RND_DOWN: up = sign_i;
        RND_UP:   up = !sign_i;
        default:  up = (sub > (eps >> 1)) || (sub == (eps >> 1) && (lo & eps) != '0);
      endcase
      f = up ? hi : lo;
      if (f == '0) underflow_o = 1'b1;
      if (f >= TWO_F) begin
        f     = (f >> 1) & ~lomask;
        exp_o = exp_o + XW'(1);
      end else if (exp_o == min_e - XW'(1) && f == ONE_F) begin
        exp_o = min_e;
      end
      inexact_o = 1'b1;
    end
    frac_o = f;
  end

  always_comb begin
    p_step_clear_r6: assert ((frac_o & lomask) == '0);
  end
endmodule

// File: rtl/fprp_pack.sv
module fprp_pack import fprp_pkg::*; #(
  parameter int XW = 17
) (
  input  logic                 sign_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 dbl_i,
  input  logic [1:0]           rnd_i,
  input  logic                 trap_of_i,
  input  logic                 inexact_i,
  input  logic                 underflow_i,
  output logic [63:0]          result_o,
  output logic                 inexact_o,
  output logic                 underflow_o,
  output logic                 overflow_o
);
  logic signed [XW-1:0] max_e, min_e, wrap, e;
  logic [FRAC_W-1:0]    eps, maxf, f;
  logic                 to_inf;
  logic [10:0]          efield;
  logic                 unused_bits;

  always_comb begin
    max_e = dbl_i ? XW'(DBL_MAX) : XW'(SGL_MAX);
    min_e = dbl_i ? XW'(DBL_MIN) : XW'(SGL_MIN);
    wrap  = dbl_i ? XW'(DBL_WRAP) : XW'(SGL_WRAP);
    eps   = FRAC_W'(1) << (dbl_i ? DBL_STEP : SGL_STEP);
    maxf  = TWO_F - eps;
    e     = exp_i;
    f     = frac_i;
    to_inf      = 1'b0;
    overflow_o  = 1'b0;
    inexact_o   = inexact_i;
    underflow_o = underflow_i;
    if (exp_i > max_e) begin
      overflow_o = 1'b1;
      inexact_o  = 1'b1;
      if (trap_of_i) begin
        e = exp_i - wrap;
      end else begin
        unique case (rnd_e'(rnd_i))
          RND_NEAR: to_inf = 1'b1;
          RND_ZERO: to_inf = 1'b0;
          RND_DOWN: to_inf = sign_i;
          default:  to_inf = !sign_i;
        endcase
        if (to_inf) begin
          e = max_e + XW'(1);
          f = '0;
        end else begin
          e = max_e;
          f = maxf;
        end
      end
    end
    if (e > max_e)      efield = 11'h7FF;
    else if (e < min_e) efield = 11'h000;
    else                efield = 11'(e + XW'(BIAS));
    result_o = {sign_i, efield, f[ONE_POS-1:GRD_W]};
  end

  assign unused_bits = ^{f[FRAC_W-1:ONE_POS], f[GRD_W-1:0]};
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack import fprp_pkg::*; #(
  parameter int EXP_W = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic                    dbl_i,
  input  logic [1:0]              rnd_i,
  input  logic                    trap_uf_i,
  input  logic                    trap_of_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [63:0]             result_o,
  output logic                    inexact_o,
  output logic                    underflow_o,
  output logic                    overflow_o
);
  localparam int XW = EXP_W + 3;

  logic signed [XW-1:0] exp_x, exp_n, exp_r;
  logic [FRAC_W-1:0]    frac_n, frac_r;
  logic                 inx_r, uf_r;
  logic [63:0]          res_p;
  logic                 inx_p, uf_p, of_p;
  logic                 zero_in;
  logic [63:0]          res_d;
  logic [2:0]           flg_d;

  assign exp_x   = XW'(exp_i);
  assign zero_in = (frac_i == '0);

  fprp_norm #(.XW(XW)) u_norm (
    .frac_i(frac_i), .exp_i(exp_x), .frac_o(frac_n), .exp_o(exp_n)
  );

  fprp_round #(.XW(XW)) u_rnd (
    .sign_i(sign_i), .exp_i(exp_n), .frac_i(frac_n), .dbl_i(dbl_i),
    .rnd_i(rnd_i), .trap_uf_i(trap_uf_i), .exp_o(exp_r), .frac_o(frac_r),
    .inexact_o(inx_r), .underflow_o(uf_r)
  );

  fprp_pack #(.XW(XW)) u_pack (
    .sign_i(sign_i), .exp_i(exp_r), .frac_i(frac_r), .dbl_i(dbl_i),
    .rnd_i(rnd_i), .trap_of_i(trap_of_i), .inexact_i(inx_r),
    .underflow_i(uf_r), .result_o(res_p), .inexact_o(inx_p),
    .underflow_o(uf_p), .overflow_o(of_p)
  );

  assign res_d = zero_in ? {sign_i, 63'd0} : res_p;
  assign flg_d = zero_in ? 3'b000 : {inx_p, uf_p, of_p};

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        {inexact_o, underflow_o, overflow_o} <= flg_d;
      end
    end
  end

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o)
      && $stable(inexact_o) && $stable(underflow_o) && $stable(overflow_o));

  p_signed_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && frac_i == '0 |=> result_o[62:0] == '0
      && result_o[63] == $past(sign_i) && !inexact_o && !underflow_o && !overflow_o);

  p_ovf_inexact_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && overflow_o |-> inexact_o);

  p_unf_inexact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && underflow_o |-> inexact_o);
endmodule

// File: tb/fp_round_pack_test.sv
`timescale 1ns/1ps
module fp_round_pack_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        sign_i = 1'b0;
  logic signed [13:0] exp_i = '0;
  logic [63:0] frac_i = '0;
  logic        dbl_i = 1'b1;
  logic [1:0]  rnd_i = 2'b00;
  logic        trap_uf_i = 1'b0;
  logic        trap_of_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] result_o;
  logic        inexact_o, underflow_o, overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  localparam logic [63:0] ONE = 64'h1 << 55;
  localparam logic [63:0] TWO = 64'h1 << 56;

  fp_round_pack #(.EXP_W(14)) uut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // {inexact, underflow, overflow, result}
  function automatic logic [66:0] model(bit s, int e, logic [63:0] f, bit dbl,
                                        bit [1:0] rm, bit tu, bit to);
    logic [63:0] eps, mxf, lo, hi;
    int mn, mx, al;
    bit inx, uf, of, up;
    logic [10:0] ef;
    inx = 0; uf = 0; of = 0; up = 0;
    if (f == 0) return {3'b000, s, 63'h0};
    while (f >= TWO) begin f = (f >> 1) | (f & 64'h1); e++; end
    while (f < ONE) begin f = (f << 1) | (f & 64'h1); e--; end
    if (dbl) begin mn = -1022; mx = 1023; al = 1536; eps = 64'h8; end
    else begin mn = -126; mx = 127; al = 192; eps = 64'h1 << 32; end
    mxf = TWO - eps;
    if (e < mn) begin
      inx = 1;
      if (tu) begin uf = 1; e += al; end
      else begin
        while (e < mn) begin e++; f = (f >> 1) | (f & 64'h1); end
        e = mn - 1;
      end
    end
    if ((f & (eps - 1)) != 0) begin
      lo = f & mxf;
      hi = lo + eps;
      case (rm)
        2'b01: up = 0;
        2'b10: up = s;
        2'b11: up = !s;
        default: up = ((f - lo) > (hi - f)) || ((f - lo) == (hi - f) && (lo & eps) != 0);
      endcase
      f = up ? hi : lo;
      if (f == 0) uf = 1;
      if (f >= TWO) begin f = (f >> 1) & ~(eps - 1); e++; end
      else if (e == mn - 1 && f == ONE) e = mn;
      inx = 1;
    end
    if (e > mx) begin
      of = 1; inx = 1;
      if (to) e -= al;
      else begin
        case (rm)
          2'b00: up = 1;
          2'b01: up = 0;
          2'b10: up = s;
          default: up = !s;
        endcase
        if (up) begin e = mx + 1; f = 0; end
        else begin e = mx; f = mxf; end
      end
    end
    if (e > mx) ef = 11'h7FF;
    else if (e < mn) ef = 11'h0;
    else ef = 11'(e + 1023);
    return {inx, uf, of, s, ef, f[54:3]};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [66:0] act, input logic [66:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual flags=%b result=%h expected flags=%b result=%h",
               tag, act[66:64], act[63:0], exp_v[66:64], exp_v[63:0]);
    end
  endtask

  task automatic run(input bit s, input int e, input logic [63:0] f, input bit d,
                     input bit [1:0] rm, input bit tu, input bit to,
                     input string tag, input logic [66:0] exp_v);
    logic [66:0] act;
    @(negedge clk_i);
    sign_i = s; exp_i = 14'(e); frac_i = f; dbl_i = d; rnd_i = rm;
    trap_uf_i = tu; trap_of_i = to; in_valid_i = 1'b1; out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    act = {inexact_o, underflow_o, overflow_o, result_o};
    check(tag, out_valid_o && act == exp_v, act, exp_v);
  endtask

  initial begin
    logic [66:0] act;
    repeat (3) @(negedge clk_i);
    act = {inexact_o, underflow_o, overflow_o, result_o};
    check("R13 reset: out_valid low, ready high", !out_valid_o && in_ready_o, act, 67'h0);
    rst_ni = 1'b1;

    run(0, 0, ONE, 1, 2'b00, 0, 0, "R11 one packs 0x3FF", {3'b000, 64'h3FF0000000000000});
    run(0, 0, 64'h3 << 55, 1, 2'b00, 0, 0, "R1 right normalise", {3'b000, 64'h4008000000000000});
    run(0, 0, TWO | 64'h1, 1, 2'b00, 0, 0, "R1 sticky kept", {3'b100, 64'h4000000000000000});
    run(0, 0, 64'h2, 1, 2'b00, 0, 0, "R2 left normalise", {3'b000, 64'h3C90000000000000});
    run(0, 0, 64'h1, 1, 2'b00, 0, 0, "R2 bit0 replicated", {3'b100, 64'h3C90000000000000});
    run(0, 0, ONE | (64'h1 << 32) | (64'h1 << 31), 0, 2'b00, 0, 0, "R3 single step", {3'b100, 64'h3FF0000040000000});
    run(0, 0, ONE | 64'h1, 0, 2'b00, 0, 0, "R3 single sticky", {3'b100, 64'h3FF0000000000000});
    run(0, -1023, ONE, 1, 2'b00, 0, 0, "R4 denormal", {3'b100, 64'h0008000000000000});
    run(0, -1200, ONE, 1, 2'b01, 0, 0, "R4 rounds to zero", {3'b110, 64'h0});
    run(0, -1023, ONE, 1, 2'b00, 1, 0, "R5 double wrap", {3'b110, 64'h6000000000000000});
    run(0, -127, ONE, 0, 2'b00, 1, 0, "R5 single wrap", {3'b110, 64'h4400000000000000});
    run(0, 0, ONE | 64'h1, 1, 2'b01, 0, 0, "R6 toward zero", {3'b100, 64'h3FF0000000000000});
    run(0, 0, ONE | 64'h1, 1, 2'b11, 0, 0, "R6 up positive", {3'b100, 64'h3FF0000000000001});
    run(0, 0, ONE | 64'h1, 1, 2'b10, 0, 0, "R6 down positive", {3'b100, 64'h3FF0000000000000});
    run(1, 0, ONE | 64'h1, 1, 2'b10, 0, 0, "R6 down negative", {3'b100, 64'hBFF0000000000001});
    run(1, 0, ONE | 64'h1, 1, 2'b11, 0, 0, "R6 up negative", {3'b100, 64'hBFF0000000000000});
    run(0, 0, ONE | 64'h4, 1, 2'b00, 0, 0, "R7 tie to even down", {3'b100, 64'h3FF0000000000000});
    run(0, 0, ONE | 64'hC, 1, 2'b00, 0, 0, "R7 tie to even up", {3'b100, 64'h3FF0000000000002});
    run(0, 0, TWO - 64'h1, 1, 2'b00, 0, 0, "R8 carry to two", {3'b100, 64'h4000000000000000});
    run(0, -1023, TWO - 64'h1, 1, 2'b00, 0, 0, "R8 denormal to min normal", {3'b100, 64'h0010000000000000});
    run(0, 1024, ONE, 1, 2'b00, 0, 1, "R9 overflow wrap", {3'b101, 64'h1FF0000000000000});
    run(0, 1024, ONE, 1, 2'b00, 0, 0, "R10 nearest inf", {3'b101, 64'h7FF0000000000000});
    run(0, 1024, ONE, 1, 2'b01, 0, 0, "R10 chop max", {3'b101, 64'h7FEFFFFFFFFFFFFF});
    run(0, 1024, ONE, 1, 2'b10, 0, 0, "R10 down positive max", {3'b101, 64'h7FEFFFFFFFFFFFFF});
    run(1, 1024, ONE, 1, 2'b10, 0, 0, "R10 down negative inf", {3'b101, 64'hFFF0000000000000});
    run(0, 1024, ONE, 1, 2'b11, 0, 0, "R10 up positive inf", {3'b101, 64'h7FF0000000000000});
    run(1, 1024, ONE, 1, 2'b11, 0, 0, "R10 up negative max", {3'b101, 64'hFFEFFFFFFFFFFFFF});
    run(0, 128, ONE, 0, 2'b01, 0, 0, "R10 single chop max", {3'b101, 64'h47EFFFFFE0000000});
    run(1, 500, 64'h0, 1, 2'b00, 0, 0, "R12 signed zero", {3'b000, 64'h8000000000000000});

    // R13 handshake hold
    @(negedge clk_i);
    sign_i = 0; exp_i = 14'(0); frac_i = ONE; dbl_i = 1; rnd_i = 2'b00;
    trap_uf_i = 0; trap_of_i = 0; in_valid_i = 1; out_ready_i = 0;
    @(negedge clk_i);
    act = {inexact_o, underflow_o, overflow_o, result_o};
    check("R13 first result", out_valid_o && act == {3'b000, 64'h3FF0000000000000}, act, {3'b000, 64'h3FF0000000000000});
    exp_i = 14'(1);
    check("R13 ready low while stalled", !in_ready_o, {66'h0, in_ready_o}, 67'h0);
    @(negedge clk_i);
    act = {inexact_o, underflow_o, overflow_o, result_o};
    check("R13 held while stalled", out_valid_o && act == {3'b000, 64'h3FF0000000000000}, act, {3'b000, 64'h3FF0000000000000});
    out_ready_i = 1;
    @(negedge clk_i);
    in_valid_i = 0;
    act = {inexact_o, underflow_o, overflow_o, result_o};
    check("R13 second result", out_valid_o && act == {3'b000, 64'h4000000000000000}, act, {3'b000, 64'h4000000000000000});
    @(negedge clk_i);
    check("R13 valid drops", !out_valid_o, {66'h0, out_valid_o}, 67'h0);

    // randomised sweep across R1..R11
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [63:0] f;
      bit d, s, tu, to;
      bit [1:0] rm;
      int e;
      f = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 16 == 0) f = 64'h0;
      d  = 1'($urandom % 2);
      s  = 1'($urandom % 2);
      tu = 1'($urandom % 2);
      to = 1'($urandom % 2);
      rm = 2'($urandom % 4);
      if (d) e = int'($urandom % 2300) - 1150;
      else e = int'($urandom % 360) - 180;
      run(s, e, f, d, rm, tu, to, "R1..R11 random vs model", model(s, e, f, d, rm, tu, to));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule